// File: doc/BRIEF.md
# Gated-Clock Parallel-In Serial-Out Shift Register

This block is an eight-stage shift register that loads in parallel and shifts out in series. It sits inside a fast system-clock domain. Its control and data pins arrive from outside that domain and are sampled there. There are two clock pins, `ck_p` and `ck_q`, and they are interchangeable. The register sees a single effective clock, which is the OR of the two pins. Holding one pin high therefore blocks edges on the other pin. A rising edge on the blocking pin while the other pin is low still counts as a shift edge.

A low level on `load_n` copies `pdata` into every stage. This overrides any clock activity. While `load_n` stays low, the stages follow `pdata`. When `load_n` is high, each rising edge of the effective clock moves `sdata` into the first stage and moves every stage one place toward the last stage. The last stage drives `q_last`, and `q_last_n` carries its complement.

Every pin passes through a two-flop synchronizer. A small state machine, `piso_edge_fsm`, then turns the synchronized levels into one-cycle load and shift commands. It has three states:
- `ST_LOAD`: load is asserted.
- `ST_ARMED`: load is released and the combined clock is low.
- `ST_HELD`: load is released and the combined clock is high.

Its transitions work as follows:
- Any state goes to `ST_LOAD` while the synchronized `load_n` is low.
- `ST_LOAD` leaves to `ST_HELD` if the combined clock is high when load is released, and to `ST_ARMED` otherwise.
- `ST_ARMED` goes to `ST_HELD` when the combined clock goes high. This transition is the only one that issues a shift.
- `ST_HELD` returns to `ST_ARMED` when the combined clock falls.

Top module: `piso_gated_shift`

## Requirements
- R1: After reset every stage is zero, so `q_last` is 0 and `q_last_n` is 1.
- R2: While `load_n` is low, every stage takes the value of `pdata`, whatever the clock pins do. Bit 7 of `pdata` goes to the last stage.
- R3: While `load_n` stays low, changes on `pdata` pass into the stages, so the load is transparent.
- R4: With `load_n` high, each rising edge of (`ck_p` OR `ck_q`) shifts the register once. `sdata` enters stage 0, stage i moves to stage i+1, and stage 7 drives `q_last`. Eight shifts read out the last eight `sdata` values in order.
- R5: `ck_p` and `ck_q` clock the register identically.
- R6: While one clock pin is held high, pulses on the other pin cause no shift.
- R7: A rise of one pin while the other pin is low shifts exactly once. A rise while the other pin is already high does not shift.
- R8: `q_last_n` is always the complement of `q_last`.
- R9: A pin change takes effect in the stages on the third `sys_clk` rising edge after it is driven. It is not yet visible after the second edge.
- R10: If `load_n` rises while the combined clock is already high, no shift occurs. The next rising edge of the combined clock shifts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Low: parallel load; high: shifting allowed |
| pdata | input | 8 | Parallel data; bit 7 goes to the last stage |
| sdata | input | 1 | Serial data into stage 0 |
| ck_p | input | 1 | Clock pin, interchangeable with ck_q |
| ck_q | input | 1 | Clock pin, interchangeable with ck_p |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The assertions check four things on every cycle:
- that an active load copies the synchronized parallel word;
- that a shift command moves the chain by exactly one place and brings in the synchronized serial bit;
- that the chain holds still when neither command is active, and that shifts never occur during a load or in two cycles back to back;
- that the two outputs stay complementary.

Some behaviours can only be shown by the bench's pin-level scenarios:
- that the clock pins are interchangeable;
- how inhibiting interacts with the combined clock, including a rising inhibit pin acting as an edge;
- load transparency;
- the three-edge latency;
- the no-shift-on-release case.

// File: rtl/piso_pkg.sv
package piso_pkg;
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } ck_state_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_V;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/piso_edge_fsm.sv
module piso_edge_fsm
    import piso_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_n_s,
    input  logic ck_or_s,
    output logic load_en,
    output logic shift_en
);
    ck_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!ld_n_s) begin
            state_nx = ST_LOAD;
        end else begin
            unique case (state)
                ST_LOAD:  state_nx = ck_or_s ? ST_HELD : ST_ARMED;
                ST_ARMED: state_nx = ck_or_s ? ST_HELD : ST_ARMED;
                ST_HELD:  state_nx = ck_or_s ? ST_HELD : ST_ARMED;
                default:  state_nx = ST_ARMED;
            endcase
        end
    end

    always_comb begin
        load_en  = !ld_n_s;
        shift_en = 1'b0;
        unique case (state)
            ST_LOAD:  shift_en = 1'b0;
            ST_ARMED: shift_en = ld_n_s && ck_or_s;
            ST_HELD:  shift_en = 1'b0;
            default:  shift_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/piso_chain.sv
module piso_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] par,
    input  logic             ser,
    output logic [WIDTH-1:0] stage
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stage <= '0;
        else if (load_en)  stage <= par;
        else if (shift_en) stage <= {stage[WIDTH-2:0], ser};
    end
endmodule

// File: rtl/piso_gated_shift.sv
module piso_gated_shift #(
    parameter int WIDTH     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] pdata,
    input  logic             sdata,
    input  logic             ck_p,
    input  logic             ck_q,
    output logic             q_last,
    output logic             q_last_n
);
    localparam int BW = WIDTH + 4;
    localparam logic [BW-1:0] BUS_RST = {1'b1, {(BW-1){1'b0}}};

    logic [BW-1:0]    raw_bus, sync_bus;
    logic             ld_n_s, ser_s, cp_s, cq_s;
    logic [WIDTH-1:0] par_s;
    logic             load_en, shift_en;
    logic [WIDTH-1:0] stage;

    assign raw_bus = {load_n, sdata, ck_p, ck_q, pdata};

    piso_sync #(.W(BW), .STAGES(SYNC_DEPTH), .RST_V(BUS_RST)) u_sync (
        .clk(sys_clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
    );

    assign {ld_n_s, ser_s, cp_s, cq_s, par_s} = sync_bus;

    piso_edge_fsm u_fsm (
        .clk(sys_clk), .rst_n(rst_n), .ld_n_s(ld_n_s),
        .ck_or_s(cp_s | cq_s), .load_en(load_en), .shift_en(shift_en)
    );

    piso_chain #(.WIDTH(WIDTH)) u_chain (
        .clk(sys_clk), .rst_n(rst_n), .load_en(load_en),
        .shift_en(shift_en), .par(par_s), .ser(ser_s), .stage(stage)
    );

    assign q_last   = stage[WIDTH-1];
    assign q_last_n = ~stage[WIDTH-1];
endmodule

// File: rtl/piso_gated_shift_chk.sv
module piso_gated_shift_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic             shift_en,
    input logic             ld_n_s,
    input logic [WIDTH-1:0] par_s,
    input logic             ser_s,
    input logic [WIDTH-1:0] stage,
    input logic             q_last,
    input logic             q_last_n
);
    assert_compl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_last_n == !q_last);

    assert_load_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> stage == $past(par_s));

    assert_shift_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load_en) |=> stage == {$past(stage[WIDTH-2:0]), $past(ser_s)});

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(stage));

    assert_no_shift_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n_s |-> !shift_en);

    assert_single_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !shift_en);
endmodule

bind piso_gated_shift piso_gated_shift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(sys_clk), .rst_n(rst_n), .load_en(load_en), .shift_en(shift_en),
    .ld_n_s(ld_n_s), .par_s(par_s), .ser_s(ser_s), .stage(stage),
    .q_last(q_last), .q_last_n(q_last_n)
);

// File: tb/piso_gated_shift_test.sv
module piso_gated_shift_test;
    logic       sys_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       load_n  = 1'b1;
    logic [7:0] pdata   = 8'h00;
    logic       sdata   = 1'b0;
    logic       ck_p    = 1'b0;
    logic       ck_q    = 1'b0;
    logic       q_last, q_last_n;

    typedef struct {
        string tag;
        bit    exp;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     chk_ev;
    int       n_cmp  = 0;
    int       n_bad  = 0;
    bit       done   = 1'b0;
    logic [7:0] model = 8'h00;

    always #10 sys_clk = ~sys_clk;

    piso_gated_shift uut (
        .sys_clk(sys_clk), .rst_n(rst_n), .load_n(load_n), .pdata(pdata),
        .sdata(sdata), .ck_p(ck_p), .ck_q(ck_q),
        .q_last(q_last), .q_last_n(q_last_n)
    );

    // monitor: pops expectations and compares against outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (q_last !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: q_last=%b expected %b", it.tag, q_last, it.exp);
                end else if (q_last_n !== !it.exp) begin
                    n_bad++;
                    $display("FAIL R8 (%s): q_last_n=%b expected %b", it.tag, q_last_n, !it.exp);
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic expect_bit(input string tag, input bit e);
        sb_item_t it;
        it.tag = tag;
        it.exp = e;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic settle;
        wait_n(4);
    endtask

    task automatic shift_model(input bit b);
        model = {model[6:0], b};
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        settle();
        expect_bit("R1 reset", 1'b0);

        // parallel load and transparency
        load_n = 1'b0; pdata = 8'hA5; model = 8'hA5; settle();
        expect_bit("R2 load", model[7]);
        pdata = 8'h5A; model = 8'h5A; settle();
        expect_bit("R3 transparent", model[7]);
        pdata = 8'h80; model = 8'h80; settle();
        expect_bit("R3 transparent", model[7]);
        ck_p = 1'b1; settle();
        expect_bit("R2 clock ignored in load", model[7]);
        ck_p = 1'b0; pdata = 8'hB3; model = 8'hB3; settle();
        load_n = 1'b1; settle();
        expect_bit("R2 release no shift", model[7]);

        // full readout, alternating clock pins (R4, R5)
        for (int i = 0; i < 8; i++) begin
            bit b;
            b = ((8'h6C >> i) & 1) != 0;
            sdata = b; settle();
            if (i % 2 == 0) ck_p = 1'b1; else ck_q = 1'b1;
            settle();
            shift_model(b);
            expect_bit(i % 2 == 0 ? "R4 readout ck_p" : "R5 readout ck_q", model[7]);
            ck_p = 1'b0; ck_q = 1'b0; settle();
        end

        // inhibit held high (R6, R7)
        sdata = 1'b1; settle();
        ck_p = 1'b1; settle(); shift_model(1'b1);
        expect_bit("R6 first edge", model[7]);
        sdata = 1'b0; ck_q = 1'b1; settle();
        expect_bit("R7 inhibit rise while high", model[7]);
        ck_p = 1'b0; settle();
        ck_p = 1'b1; settle();
        expect_bit("R6 inhibited pulse", model[7]);
        ck_p = 1'b0; settle();
        ck_q = 1'b0; settle();
        expect_bit("R6 inhibit fall", model[7]);

        // inhibit rising while clock low acts as edge (R7)
        sdata = 1'b1; settle();
        ck_q = 1'b1; settle(); shift_model(1'b1);
        expect_bit("R7 inhibit rise as edge", model[7]);
        ck_q = 1'b0; settle();

        // load release with combined clock high (R10)
        load_n = 1'b0; pdata = 8'h40; model = 8'h40; settle();
        expect_bit("R10 preload", model[7]);
        ck_p = 1'b1; settle();
        load_n = 1'b1; settle();
        expect_bit("R10 no shift on release", model[7]);
        ck_p = 1'b0; sdata = 1'b0; settle();

        // latency (R9) on the next edge, q_last goes 0 -> 1
        ck_p = 1'b1;
        wait_n(2);
        expect_bit("R9 not yet after two edges", 1'b0);
        wait_n(1);
        shift_model(1'b0);
        expect_bit("R9 visible after third edge", model[7]);
        expect_bit("R10 next edge shifts", 1'b1);
        ck_p = 1'b0; settle();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge sys_clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule